// File: doc/BRIEF.md
# HDLC Receive Frame Formatter

This block sits between an HDLC receive deframer and a receive FIFO. The deframer has already removed flags and stuffed zero bits. It delivers one byte per valid cycle, with markers for the first and last byte of a frame and a separate abort pulse. The formatter decides which bytes reach the FIFO write port and closes every frame with one status byte.

Two per-frame controls shape the stored stream. One keeps or drops the leading address field, which is one or two bytes long. The other keeps or drops the trailing two-byte frame check sequence. Keeping the address is honoured only in the non-auto and transparent-1 operating modes. Keeping the check sequence is honoured only in the non-auto mode. The CRC-16 check runs on every frame, whether or not the check bytes are stored. The status byte reports length validity, CRC result, abort and FIFO overflow. When the check bytes are dropped, a two-entry hold line delays the data so the final two bytes can be discarded once the frame ends.

Top module: `hdlc_rx_fifo_fmt`

## Requirements
- R1: While reset is asserted, `fifo_we_o` is 0 and `fifo_data_o` is 0. The latched per-frame controls reset to "do not store address" and "do not store check bytes".
- R2: The address field is the first byte of the frame, or the first two bytes when `addr_two_i` is 1. It is written only when `addr_push_i` is 1 and `mode_i` is 2'b01 (non-auto) or 2'b10 (transparent-1). In mode 2'b00 (auto) and 2'b11 (transparent-0) it is never written.
- R3: When `crc_store_i` is 1 and `mode_i` is 2'b01, the last two bytes of the frame are written in the order received. Otherwise they never reach the FIFO.
- R4: All bytes that are neither address nor check bytes are written in arrival order. A write occurs only in a cycle following a received byte or a pending status byte.
- R5: Each frame ends with exactly one status byte, written after the frame's data. It appears on the write port on the second rising edge after the last-byte cycle. Its layout is bit 7 valid-frame, bit 6 overflow, bit 5 CRC-ok, bit 4 abort, and bits 3:0 zero.
- R6: CRC-ok is 1 when the CRC-16 (reflected polynomial 0x8408, preset 0xFFFF, bits taken LSB first) run over all frame bytes, including the check bytes, leaves 0xF0B8.
- R7: Valid-frame is 1 when the frame was not aborted and its total byte count is at least 4 with check bytes dropped, or at least 3 with check bytes stored.
- R8: An abort pulse inside a frame discards any held bytes. It writes, on the second rising edge, a status byte with abort=1, valid-frame=0 and CRC-ok=0. An abort pulse outside a frame has no effect.
- R9: A data write that meets `fifo_full_i`=1 is dropped, and the overflow bit of that frame's status is set. The status byte is written regardless of `fifo_full_i`.
- R10: The mode, address-keep, check-keep and address-length controls are sampled on the frame's first byte. Changes during the frame have no effect on it.
- R11: The source leaves at least one idle cycle after a last byte. A new frame may start in the cycle after that idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode: 00 auto, 01 non-auto, 10 transparent-1, 11 transparent-0 |
| addr_push_i | input | 1 | Keep the address field in the FIFO |
| crc_store_i | input | 1 | Keep the two check bytes in the FIFO |
| addr_two_i | input | 1 | Address field length: 0 one byte, 1 two bytes |
| byte_valid_i | input | 1 | A received byte is present |
| byte_i | input | 8 | Received byte |
| sof_i | input | 1 | Byte is the first of a frame |
| eof_i | input | 1 | Byte is the last of a frame |
| abort_i | input | 1 | Frame aborted (pulse, no byte in the same cycle) |
| fifo_full_i | input | 1 | FIFO cannot accept a data byte |
| fifo_we_o | output | 1 | FIFO write enable |
| fifo_data_o | output | 8 | FIFO write data |

## Verification
A hold line that keeps a stale entry or empties at the wrong moment shows up as a wrong byte or a wrong byte count in the frame's FIFO image. The status byte of that same frame is already late or misplaced by then. A corrupted CRC register or length counter has no effect on the data bytes. It shows only in the status byte, two edges after the last byte. For this reason every scenario compares the complete write sequence, status included, against a model built from the requirements. A lost per-frame control latch shows up as extra or missing address or check bytes in the frame that follows the change.

// File: rtl/hdlc_fmt_pkg.sv
package hdlc_fmt_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO    = 2'b00,
    MODE_NONAUTO = 2'b01,
    MODE_TRANSP1 = 2'b10,
    MODE_TRANSP0 = 2'b11
  } rx_mode_e;

  localparam int unsigned ST_VALID = 7;
  localparam int unsigned ST_OVF   = 6;
  localparam int unsigned ST_CRC   = 5;
  localparam int unsigned ST_ABORT = 4;

  localparam int unsigned CRC_BYTES = 2;

  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;

  typedef struct packed {
    logic       keep;
    logic [7:0] data;
  } held_t;

endpackage

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
  parameter logic [15:0] POLY   = hdlc_fmt_pkg::CRC_POLY_REV,
  parameter logic [15:0] PRESET = hdlc_fmt_pkg::CRC_PRESET
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        restart_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_next_o
);

  logic [15:0] crc_q;

  always_comb begin
    logic [15:0] c;
    logic        fb;
    c = restart_i ? PRESET : crc_q;
    for (int b = 0; b < 8; b++) begin
      fb = c[0] ^ data_i[b];
      c  = {1'b0, c[15:1]};
      if (fb) c = c ^ POLY;
    end
    crc_next_o = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= PRESET;
    else if (en_i) crc_q <= crc_next_o;
  end

endmodule

// File: rtl/hdlc_frame_ctr.sv
module hdlc_frame_ctr #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             first_i,
  input  logic             two_i,
  output logic             is_addr_o,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;

  assign idx       = first_i ? '0 : cnt_q;
  assign is_addr_o = idx < (two_i ? CNT_W'(2) : CNT_W'(1));
  // saturating: only the comparison against the minimum length matters
  assign len_o     = (idx == CNT_MAX) ? CNT_MAX : idx + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= len_o;
  end

endmodule

// File: rtl/hdlc_hold_line.sv
module hdlc_hold_line #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         clear_i,
  input  logic [W-1:0] data_i,
  output logic         out_vld_o,
  output logic [W-1:0] out_data_o
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic         v_q;
    logic [W-1:0] d_q;
    logic         src_v;
    logic [W-1:0] src_d;

    if (s == 0) begin : g_head
      assign src_v = 1'b1;
      assign src_d = data_i;
    end else begin : g_tail
      assign src_v = g_stage[s-1].v_q;
      assign src_d = g_stage[s-1].d_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (clear_i) begin
        v_q <= 1'b0;
      end else if (push_i) begin
        v_q <= src_v;
        d_q <= src_d;
      end
    end
  end

  assign out_vld_o  = g_stage[DEPTH-1].v_q;
  assign out_data_o = g_stage[DEPTH-1].d_q;

endmodule

// File: rtl/hdlc_rx_fifo_fmt.sv
module hdlc_rx_fifo_fmt
  import hdlc_fmt_pkg::*;
#(
  parameter int unsigned MIN_LEN_STRIP = 4,
  parameter int unsigned MIN_LEN_KEEP  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       addr_push_i,
  input  logic       crc_store_i,
  input  logic       addr_two_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic       abort_i,
  input  logic       fifo_full_i,
  output logic       fifo_we_o,
  output logic [7:0] fifo_data_o
);

  localparam int unsigned LEN_MAX = (MIN_LEN_STRIP > MIN_LEN_KEEP) ? MIN_LEN_STRIP : MIN_LEN_KEEP;
  localparam int unsigned CNT_RAW = $clog2(LEN_MAX + 1);
  localparam int unsigned CNT_W   = (CNT_RAW < 2) ? 2 : CNT_RAW;
  localparam logic [CNT_W-1:0] MIN_S = CNT_W'(MIN_LEN_STRIP);
  localparam logic [CNT_W-1:0] MIN_K = CNT_W'(MIN_LEN_KEEP);
  localparam int unsigned HELD_W = $bits(held_t);

  rx_mode_e mode_in;
  logic     in_frame_q;
  logic     cfg_addr_q, cfg_crc_q, cfg_two_q;
  logic     byte_first, accept, end_byte, abort_ev;
  logic     in_addr_eff, in_crc_eff;
  logic     cur_addr, cur_crc, cur_two;
  logic     is_addr, keep;
  logic [CNT_W-1:0] len;
  logic [15:0] crc_next;
  held_t    held_in, held_out;
  logic     held_vld;
  logic     hold_push, hold_clear;
  logic     wr_req, wr_ok, ovf_hit, ovf_now, ovf_q;
  logic [7:0] wr_data;
  logic     stat_pend_q;
  logic [7:0] stat_q, stat_d;

  assign mode_in     = rx_mode_e'(mode_i);
  assign in_addr_eff = addr_push_i & ((mode_in == MODE_NONAUTO) | (mode_in == MODE_TRANSP1));
  assign in_crc_eff  = crc_store_i & (mode_in == MODE_NONAUTO);

  assign abort_ev   = abort_i & in_frame_q;
  assign byte_first = byte_valid_i & sof_i & ~abort_ev;
  assign accept     = byte_valid_i & (sof_i | in_frame_q) & ~abort_ev;
  assign end_byte   = accept & eof_i;

  // controls apply from the first byte, then stay latched for the frame
  assign cur_addr = byte_first ? in_addr_eff : cfg_addr_q;
  assign cur_crc  = byte_first ? in_crc_eff  : cfg_crc_q;
  assign cur_two  = byte_first ? addr_two_i  : cfg_two_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_addr_q <= 1'b0;
      cfg_crc_q  <= 1'b0;
      cfg_two_q  <= 1'b0;
    end else if (byte_first) begin
      cfg_addr_q <= in_addr_eff;
      cfg_crc_q  <= in_crc_eff;
      cfg_two_q  <= addr_two_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   in_frame_q <= 1'b0;
    else if (end_byte | abort_ev)  in_frame_q <= 1'b0;
    else if (byte_first)           in_frame_q <= 1'b1;
  end

  hdlc_frame_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (accept),
    .first_i   (byte_first),
    .two_i     (cur_two),
    .is_addr_o (is_addr),
    .len_o     (len)
  );

  hdlc_crc16 i_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (accept),
    .restart_i  (byte_first),
    .data_i     (byte_i),
    .crc_next_o (crc_next)
  );

  assign keep       = ~is_addr | cur_addr;
  assign held_in    = '{keep: keep, data: byte_i};
  assign hold_push  = accept & ~cur_crc;
  assign hold_clear = end_byte | abort_ev;

  hdlc_hold_line #(.DEPTH(CRC_BYTES), .W(HELD_W)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (hold_push),
    .clear_i    (hold_clear),
    .data_i     (held_in),
    .out_vld_o  (held_vld),
    .out_data_o (held_out)
  );

  always_comb begin
    if (cur_crc) begin
      wr_req  = accept & keep;
      wr_data = byte_i;
    end else begin
      wr_req  = hold_push & held_vld & held_out.keep;
      wr_data = held_out.data;
    end
  end

  assign ovf_hit = wr_req & fifo_full_i;
  assign wr_ok   = wr_req & ~fifo_full_i;
  assign ovf_now = (byte_first ? 1'b0 : ovf_q) | ovf_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovf_q <= 1'b0;
    else if (accept) ovf_q <= ovf_now;
  end

  always_comb begin
    stat_d = '0;
    if (abort_ev) begin
      stat_d[ST_ABORT] = 1'b1;
      stat_d[ST_OVF]   = ovf_q;
    end else begin
      stat_d[ST_VALID] = len >= (cur_crc ? MIN_K : MIN_S);
      stat_d[ST_CRC]   = crc_next == CRC_RESIDUE;
      stat_d[ST_OVF]   = ovf_now;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_pend_q <= 1'b0;
      stat_q      <= '0;
    end else begin
      stat_pend_q <= end_byte | abort_ev;
      if (end_byte | abort_ev) stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_we_o   <= 1'b0;
      fifo_data_o <= '0;
    end else begin
      fifo_we_o <= stat_pend_q | wr_ok;
      if (stat_pend_q)  fifo_data_o <= stat_q;
      else if (wr_ok)   fifo_data_o <= wr_data;
    end
  end

endmodule

// File: rtl/hdlc_rx_fifo_fmt_chk.sv
module hdlc_rx_fifo_fmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_valid_i,
  input logic       eof_i,
  input logic       abort_i,
  input logic       fifo_full_i,
  input logic       fifo_we_o,
  input logic [7:0] fifo_data_o,
  input logic       stat_pend_q,
  input logic       in_frame_q
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!fifo_we_o && fifo_data_o == 8'h00); // R1
    end
  end

  AST_STATUS_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && eof_i |-> ##2 fifo_we_o); // R5

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_pend_q |=> fifo_we_o && fifo_data_o[3:0] == 4'h0); // R5

  AST_ABORT_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && in_frame_q |-> ##2 (fifo_we_o && fifo_data_o[4] && !fifo_data_o[7] && !fifo_data_o[5])); // R8

  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i && !stat_pend_q |=> !fifo_we_o); // R9

  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i && !stat_pend_q |=> !fifo_we_o); // R4

  AST_EOF_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && eof_i |=> !byte_valid_i); // R11

endmodule

bind hdlc_rx_fifo_fmt hdlc_rx_fifo_fmt_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .eof_i        (eof_i),
  .abort_i      (abort_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_we_o    (fifo_we_o),
  .fifo_data_o  (fifo_data_o),
  .stat_pend_q  (stat_pend_q),
  .in_frame_q   (in_frame_q)
);

// File: tb/test_hdlc_rx_fifo_fmt.sv
`timescale 1ns/1ps
module test_hdlc_rx_fifo_fmt;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       addr_push_i = 1'b0, crc_store_i = 1'b0, addr_two_i = 1'b0;
  logic       byte_valid_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0, abort_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       fifo_full_i = 1'b0;
  logic       fifo_we_o;
  logic [7:0] fifo_data_o;

  always #2 clk_i = ~clk_i;

  hdlc_rx_fifo_fmt i_hdlc_rx_fifo_fmt (.*);

  typedef struct packed {
    logic [1:0] mode;
    logic       push;
    logic       store;
    logic       two;
    logic [4:0] len;
    logic       bad;
    logic       abrt;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b1, 1'b1, 1'b0, 5'd6, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b1, 1'b0, 5'd6, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b1, 5'd7, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 1'b1, 5'd7, 1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b1, 1'b0, 5'd6, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b0, 5'd6, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b1, 5'd6, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 5'd3, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b0, 5'd3, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 5'd4, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b0, 5'd2, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1},
    '{2'd1, 1'b1, 1'b1, 1'b1, 5'd5, 1'b0, 1'b1}
  };

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [7:0] frame_b [32];
  int         frame_n;
  logic [7:0] exp_b [64];
  int         exp_n;
  logic [7:0] cap_b [64];
  int         cap_t [64];
  int         cap_n = 0;
  int         eof_cyc;

  always @(posedge clk_i) cyc++;

  always @(negedge clk_i) begin
    if (fifo_we_o && cap_n < 64) begin
      cap_b[cap_n] = fifo_data_o;
      cap_t[cap_n] = cyc;
      cap_n++;
    end
  end

  function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] b);
    c = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  function automatic string vtag(int k);
    case (k)
      0: return "R4 R5 R6";
      1, 3, 6: return "R2";
      2, 4, 5: return "R2 R3";
      7: return "R6";
      8, 9, 10, 11: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic make_frame(int n, bit bad, bit abrt, int seed);
    logic [15:0] c = 16'hFFFF;
    int np = abrt ? n : n - 2;
    for (int i = 0; i < np; i++) begin
      frame_b[i] = 8'(seed + 90 + i * 29);
      c = crc_upd(c, frame_b[i]);
    end
    if (!abrt) begin
      c = ~c;
      frame_b[n-2] = c[7:0];
      frame_b[n-1] = c[15:8];
      if (bad) frame_b[n-1] = frame_b[n-1] ^ 8'h04;
    end
    frame_n = n;
  endtask

  task automatic add_exp(logic [1:0] m, bit push, bit store, bit two, bit abrt, bit ovf);
    bit ae = push && (m == 2'd1 || m == 2'd2);
    bit ce = store && (m == 2'd1);
    int na = two ? 2 : 1;
    logic [15:0] r = 16'hFFFF;
    logic [7:0] st = 8'h00;
    for (int i = 0; i < frame_n; i++) begin
      r = crc_upd(r, frame_b[i]);
      if (i < na && !ae) continue;
      if (!ce && i >= frame_n - 2) continue;
      if (!ovf) begin exp_b[exp_n] = frame_b[i]; exp_n++; end
    end
    if (abrt) st[4] = 1'b1;
    else begin
      st[7] = (frame_n >= (ce ? 3 : 4));
      st[5] = (r == 16'hF0B8);
    end
    st[6] = ovf;
    exp_b[exp_n] = st;
    exp_n++;
  endtask

  task automatic send_frame(bit abrt, bit flip);
    for (int i = 0; i < frame_n; i++) begin
      @(negedge clk_i);
      if (flip && i == 1) begin
        mode_i = 2'd0; addr_push_i = 1'b0; crc_store_i = 1'b0; addr_two_i = 1'b1;
      end
      byte_valid_i = 1'b1;
      byte_i = frame_b[i];
      sof_i = (i == 0);
      eof_i = (i == frame_n - 1) && !abrt;
      if (eof_i) eof_cyc = cyc;
    end
    @(negedge clk_i);
    byte_valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
    if (abrt) begin
      abort_i = 1'b1;
      eof_cyc = cyc;
      @(negedge clk_i);
      abort_i = 1'b0;
    end
  endtask

  task automatic check_cap(string tag);
    bit ok = (cap_n == exp_n);
    int bad_i = -1;
    for (int i = 0; i < exp_n && ok; i++)
      if (cap_b[i] !== exp_b[i]) begin ok = 0; bad_i = i; end
    checks++;
    if (!ok) begin
      failures++;
      if (bad_i < 0)
        $display("FAIL %s: write count actual=%0d expected=%0d", tag, cap_n, exp_n);
      else
        $display("FAIL %s: byte %0d actual=%02h expected=%02h", tag, bad_i, cap_b[bad_i], exp_b[bad_i]);
    end
  endtask

  task automatic check_int(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic set_cfg(logic [1:0] m, bit p, bit s, bit t);
    mode_i = m; addr_push_i = p; crc_store_i = s; addr_two_i = t;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet during reset
    idle(3);
    check_int("R1 we in reset", int'(fifo_we_o), 0);
    check_int("R1 data in reset", int'(fifo_data_o), 0);
    rst_ni = 1'b1;
    idle(4);
    check_int("R1 no writes after reset", cap_n, 0);

    for (int k = 0; k < NVEC; k++) begin
      vec_t v = VECS[k];
      cap_n = 0; exp_n = 0;
      set_cfg(v.mode, v.push, v.store, v.two);
      make_frame(int'(v.len), v.bad, v.abrt, k * 7);
      add_exp(v.mode, v.push, v.store, v.two, v.abrt, 1'b0);
      send_frame(v.abrt, 1'b0);
      idle(5);
      check_cap(vtag(k));
    end

    // R5: status lands on the second edge after the last-byte cycle
    cap_n = 0; exp_n = 0;
    set_cfg(2'd1, 1'b1, 1'b1, 1'b0);
    make_frame(4, 1'b0, 1'b0, 3);
    add_exp(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    send_frame(1'b0, 1'b0);
    idle(5);
    check_cap("R5 sequence");
    check_int("R5 status timing", cap_t[cap_n > 0 ? cap_n - 1 : 0], eof_cyc + 2);

    // R9: FIFO full for the whole frame drops the data, status still written
    cap_n = 0; exp_n = 0;
    set_cfg(2'd1, 1'b1, 1'b1, 1'b0);
    make_frame(5, 1'b0, 1'b0, 11);
    add_exp(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    fifo_full_i = 1'b1;
    send_frame(1'b0, 1'b0);
    idle(5);
    fifo_full_i = 1'b0;
    check_cap("R9 overflow");

    // R10: controls changed after the first byte are ignored
    cap_n = 0; exp_n = 0;
    set_cfg(2'd1, 1'b1, 1'b1, 1'b0);
    make_frame(6, 1'b0, 1'b0, 21);
    add_exp(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    send_frame(1'b0, 1'b1);
    idle(5);
    check_cap("R10 mid-frame change");

    // R8: abort with no frame in progress does nothing
    cap_n = 0;
    @(negedge clk_i); abort_i = 1'b1;
    @(negedge clk_i); abort_i = 1'b0;
    idle(4);
    check_int("R8 idle abort", cap_n, 0);

    // R11: a frame right after the single idle cycle
    cap_n = 0; exp_n = 0;
    set_cfg(2'd1, 1'b1, 1'b1, 1'b0);
    make_frame(5, 1'b0, 1'b0, 33);
    add_exp(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    send_frame(1'b0, 1'b0);
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0);
    make_frame(6, 1'b0, 1'b0, 44);
    add_exp(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(1'b0, 1'b0);
    idle(6);
    check_cap("R11 back-to-back");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule